// File: doc/BRIEF.md
# Watchdog Supervisor with Grace Timeout

This block supervises a microprocessor through a single watchdog input. The software must make this input change level, rising or falling, often enough. If the input holds still for longer than the current timeout, the block drives an active-low reset output low for a fixed number of cycles. It also raises a one-cycle strobe at the start of that pulse. Every length is a parameter counted in clock cycles.

Firmware is often slow to start servicing the watchdog after a reset. For that reason the block starts every supervision period with a long grace timeout. It moves to the shorter normal timeout only when it sees the first input change after its reset output has gone inactive. A parameter can keep the long timeout as the only timeout.

Two flags stop supervision while they hold:
- an external detector reports that the watchdog input is floating;
- an external comparator reports that the supply is not good.

While supervision is stopped, the block is idle and its reset output stays inactive.

Top module: `wdt_supervisor`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `wdt_rst_n` is 1 and `wdt_timeout` is 0. The block restarts in long-timeout mode with its count at zero.
- R2: Take the clock edge at which `rst` is first sampled low as edge 1. If the watchdog input does not change, `wdt_rst_n` goes low at edge LONG_CYCLES.
- R3: A timeout drives `wdt_rst_n` low for exactly PULSE_CYCLES clock cycles. `wdt_timeout` is 1 only in the first cycle of that low pulse, and it is never 1 otherwise.
- R4: A rising edge and a falling edge of `wdi` each restart the count from zero. A change sampled at the same edge at which the limit would be reached counts as service, so no pulse follows.
- R5: The first `wdi` change seen while `wdt_rst_n` is high switches the block to the normal timeout. From the edge that samples a change, the pulse follows SHORT_CYCLES edges later if `wdi` does not change again.
- R6: When a pulse ends, the block returns to long-timeout mode and counts again from zero. With `wdi` held constant, pulses repeat with a period of LONG_CYCLES + PULSE_CYCLES cycles.
- R7: While `wdi_float` is 1, no pulse is produced and the count and mode are cleared. When `wdi_float` goes back to 0, a full long timeout applies, even if the block was in short mode before.
- R8: While `supply_ok` is 0, supervision stops in the same way as in R7. A pulse that is running ends at the next edge, with `wdt_rst_n` returning to 1 and no strobe.
- R9: Changes of `wdi` while `wdt_rst_n` is low have no effect. After the pulse the long timeout applies.
- R10: With FIXED_LONG = 1, the block never switches to the normal timeout. A pulse follows LONG_CYCLES edges after the last change of `wdi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| wdi | input | 1 | Watchdog service input, already synchronised |
| wdi_float | input | 1 | High when the watchdog input is floating |
| supply_ok | input | 1 | High when the supply is good |
| wdt_rst_n | output | 1 | Active-low reset pulse output, registered |
| wdt_timeout | output | 1 | One-cycle strobe at the start of a watchdog pulse |

## Verification
The properties assume that `wdi`, `wdi_float` and `supply_ok` are synchronous levels that are stable around each rising clock edge. They also assume that SHORT_CYCLES is no larger than LONG_CYCLES. The bench changes every input only on the falling clock edge, so each change of `wdi` is seen as exactly one change at the next rising edge. It keeps the flag changes well apart from the points where a timeout would expire, except where a requirement's boundary is the point of the test.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    MODE_LONG  = 1'b0,
    MODE_SHORT = 1'b1
  } wdt_mode_e;
endpackage

// File: rtl/wdt_edge_detect.sv
module wdt_edge_detect (
  input  logic clk,
  input  logic din,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    prev_q <= din;
  end

  assign edge_o = din ^ prev_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned LONG_CYCLES  = 200_000_000,
  parameter int unsigned SHORT_CYCLES = 14_000_000,
  parameter bit          FIXED_LONG   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic counting,
  input  logic edge_i,
  output logic expire_o
);
  localparam int CW = (LONG_CYCLES > 1) ? $clog2(LONG_CYCLES) : 1;
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  wdt_mode_e     mode_q;
  logic [CW-1:0] last;
  logic          active;

  assign last     = (mode_q == MODE_LONG) ? LONG_LAST : SHORT_LAST;
  assign active   = enable && counting;
  assign expire_o = active && !edge_i && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= MODE_LONG;
    end else if (!active) begin
      cnt_q  <= '0;
      mode_q <= MODE_LONG;
    end else if (edge_i) begin
      cnt_q <= '0;
      if (!FIXED_LONG) mode_q <= MODE_SHORT;
    end else if (cnt_q == last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: a sampled edge restarts the count
  a_r4_edge_restarts: assert property (@(posedge clk) disable iff (rst)
    (active && edge_i) |=> (cnt_q == '0));

  // R5: the first edge selects the normal timeout unless it is fixed long
  a_r5_short_after_edge: assert property (@(posedge clk) disable iff (rst)
    (active && edge_i && !FIXED_LONG) |=> (mode_q == MODE_SHORT));

  // R7, R8: stopped supervision stays idle in long mode
  a_r7_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt_q == '0 && mode_q == MODE_LONG));

  // R2: the count never passes the current limit
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);

  // R10: a fixed-long build never leaves long mode
  a_r10_fixed_stays_long: assert property (@(posedge clk) disable iff (rst)
    (FIXED_LONG && active && edge_i) |=> (mode_q == MODE_LONG));
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned PULSE_CYCLES = 7_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic start,
  output logic active_o,
  output logic strobe_o
);
  localparam int PW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CYCLES - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      active_o <= 1'b0;
      strobe_o <= 1'b0;
      pcnt_q   <= '0;
    end else begin
      strobe_o <= 1'b0;
      if (!active_o) begin
        if (start) begin
          active_o <= 1'b1;
          strobe_o <= 1'b1;
          pcnt_q   <= '0;
        end
      end else if (pcnt_q == PULSE_LAST) begin
        active_o <= 1'b0;
        pcnt_q   <= '0;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  // R3: the pulse counter stays within the pulse length
  a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (rst)
    active_o |-> (pcnt_q <= PULSE_LAST));

  // R3: the strobe lasts a single cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);

  // R8: losing the enable ends any pulse at the next edge
  a_r8_off_ends_pulse: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !active_o);
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int unsigned LONG_CYCLES  = 200_000_000,
  parameter int unsigned SHORT_CYCLES = 14_000_000,
  parameter int unsigned PULSE_CYCLES = 7_000_000,
  parameter bit          FIXED_LONG   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wdi,
  input  logic wdi_float,
  input  logic supply_ok,
  output logic wdt_rst_n,
  output logic wdt_timeout
);
  logic enable;
  logic wdi_edge;
  logic expire;
  logic pulse_active;

  assign enable = supply_ok && !wdi_float;

  wdt_edge_detect u_edge (
    .clk    (clk),
    .din    (wdi),
    .edge_o (wdi_edge)
  );

  wdt_timer #(
    .LONG_CYCLES  (LONG_CYCLES),
    .SHORT_CYCLES (SHORT_CYCLES),
    .FIXED_LONG   (FIXED_LONG)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .counting (!pulse_active),
    .edge_i   (wdi_edge),
    .expire_o (expire)
  );

  wdt_pulse_gen #(
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .start    (expire),
    .active_o (pulse_active),
    .strobe_o (wdt_timeout)
  );

  assign wdt_rst_n = !pulse_active;

  // R3: the strobe marks the falling edge of the reset output
  a_r3_strobe_on_fall: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |-> $fell(wdt_rst_n));

  // R3: every falling edge of the reset output carries the strobe
  a_r3_fall_has_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst_n) |-> wdt_timeout);

  // R7, R8: no reset pulse while supervision is stopped
  a_r8_off_keeps_high: assert property (@(posedge clk) disable iff (rst)
    !enable |=> wdt_rst_n);
endmodule

// File: tb/wdt_supervisor_test.sv
`timescale 1ns/1ps
module wdt_supervisor_test;
  localparam int L = 64;
  localparam int S = 16;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_fix = 1'b1;
  logic wdi = 1'b0;
  logic wdi_float = 1'b0;
  logic supply_ok = 1'b1;
  logic wdt_rst_n, wdt_timeout;
  logic fix_rst_n, fix_timeout;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    kind;   // 0 = falling edge with strobe, 1 = rising edge
    int    at;
    string req;
  } ev_t;
  ev_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_supervisor #(.LONG_CYCLES(L), .SHORT_CYCLES(S), .PULSE_CYCLES(P),
    .FIXED_LONG(1'b0)) uut (
    .clk(clk), .rst(rst), .wdi(wdi), .wdi_float(wdi_float),
    .supply_ok(supply_ok), .wdt_rst_n(wdt_rst_n), .wdt_timeout(wdt_timeout));

  wdt_supervisor #(.LONG_CYCLES(L), .SHORT_CYCLES(S), .PULSE_CYCLES(P),
    .FIXED_LONG(1'b1)) uut_fix (
    .clk(clk), .rst(rst_fix), .wdi(wdi), .wdi_float(wdi_float),
    .supply_ok(supply_ok), .wdt_rst_n(fix_rst_n), .wdt_timeout(fix_timeout));

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp_v, cyc);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic toggle();
    wdi = ~wdi;
  endtask

  task automatic check_drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: compare every change of the reset output against the queue
  logic last_n = 1'b1;
  always @(negedge clk) begin
    if (wdt_rst_n !== last_n) begin
      int kind_o;
      kind_o = (wdt_rst_n === 1'b0) ? 0 : 1;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected reset edge", kind_o, -1);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(kind_o == e.kind, {e.req, " edge kind"}, kind_o, e.kind);
        chk(cyc == e.at, {e.req, " edge cycle"}, cyc, e.at);
      end
      chk(wdt_timeout == (kind_o == 0), "R3 strobe with edge", int'(wdt_timeout),
          int'(kind_o == 0));
    end else if (wdt_timeout) begin
      chk(1'b0, "R3 strobe without falling edge", 1, 0);
    end
    last_n = wdt_rst_n;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: bench did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int c, t, f, r, e, s;
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset state
    chk(wdt_rst_n == 1'b1, "R1 reset output", int'(wdt_rst_n), 1);
    chk(wdt_timeout == 1'b0, "R1 strobe in reset", int'(wdt_timeout), 0);

    // R2, R3, R6: unserviced, repeated pulses
    c = cyc; rst = 1'b0;
    expect_ev(0, c + L, "R2");
    expect_ev(1, c + L + P, "R3");
    expect_ev(0, c + 2*L + P, "R6");
    expect_ev(1, c + 2*L + 2*P, "R6");
    wait_to(c + 2*L + 2*P + 2);
    check_drained("R6 repeated pulses");
    r = c + 2*L + 2*P;

    // R4: a change at the expiry edge services; R5: then the short timeout applies
    wait_to(r + L - 1); t = cyc; toggle();
    f = t + 1 + S;
    expect_ev(0, f, "R5");
    expect_ev(1, f + P, "R3");
    // R9: a change during the pulse is ignored
    wait_to(f + 2); toggle();
    expect_ev(0, f + P + L, "R9");
    expect_ev(1, f + 2*P + L, "R9");
    wait_to(f + 2*P + L + 2);
    check_drained("R4 R9 sequence");
    r = f + 2*P + L;

    // R4 and R5: service exactly every S cycles in short mode
    wait_to(r + 3); toggle(); t = cyc;
    for (int k = 0; k < 4; k++) begin
      t = t + S; wait_to(t); toggle();
    end
    expect_ev(0, t + 1 + S, "R4");
    expect_ev(1, t + 1 + S + P, "R5");
    wait_to(t + 1 + S + P + 2);
    check_drained("R4 short boundary");
    r = t + 1 + S + P;

    // R7: floating input stops supervision and restores long mode
    wait_to(r + 2); toggle();
    wait_to(r + 5); wdi_float = 1'b1;
    wait_to(r + 5 + L); toggle();
    wait_to(r + 5 + 3*L);
    chk(wdt_rst_n == 1'b1, "R7 no pulse while floating", int'(wdt_rst_n), 1);
    e = cyc; wdi_float = 1'b0;
    f = e + L;
    expect_ev(0, f, "R7");
    // R8: supply loss ends a running pulse at the next edge
    wait_to(f + 3); supply_ok = 1'b0;
    expect_ev(1, f + 4, "R8");
    wait_to(f + 4 + 2*L);
    chk(wdt_rst_n == 1'b1, "R8 no pulse without supply", int'(wdt_rst_n), 1);
    s = cyc; supply_ok = 1'b1;
    expect_ev(0, s + L, "R8");
    expect_ev(1, s + L + P, "R8");
    wait_to(s + L + P + 2);
    check_drained("R7 R8 sequence");
    r = s + L + P;

    // R1: a system reset during a pulse clears it
    expect_ev(0, r + L, "R6");
    wait_to(r + L + 2); rst = 1'b1;
    expect_ev(1, r + L + 3, "R1");
    wait_to(r + L + 5);
    chk(wdt_rst_n == 1'b1, "R1 output after reset", int'(wdt_rst_n), 1);
    chk(wdt_timeout == 1'b0, "R1 strobe after reset", int'(wdt_timeout), 0);
    c = cyc; rst = 1'b0;
    expect_ev(0, c + L, "R1");
    expect_ev(1, c + L + P, "R1");
    wait_to(c + L + P + 2);
    check_drained("R1 restart");

    // R10: the fixed build keeps the long timeout after a change
    rst = 1'b1;
    wait_to(cyc + 2);
    c = cyc; rst_fix = 1'b0;
    wait_to(c + 5); toggle();
    wait_to(c + 6 + L - 1);
    chk(fix_rst_n == 1'b1, "R10 no short timeout", int'(fix_rst_n), 1);
    wait_to(c + 6 + L);
    chk(fix_rst_n == 1'b0, "R10 long timeout expiry", int'(fix_rst_n), 0);
    chk(fix_timeout == 1'b1, "R10 strobe", int'(fix_timeout), 1);

    check_drained("final queue");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule